// File: doc/BRIEF.md
# Striped Dual-Word Instruction Fetch

This block is the front end of a direct-mapped, read-only instruction cache that hands two consecutive 32-bit instructions to the pipeline in each cycle. The fetch address is a word address, and it may point to any word: even or odd, anywhere in a line. Word storage is split by word parity into an even bank and an odd bank. Because of this split, the two words of any adjacent pair always sit in different banks and can be read together. One single-ported tag store with a valid bit per line serves both banks.

A pair that begins on the last word of a line needs two lines. The tag store can check only one line per cycle, so a small sequencer stalls the requester and runs two ordinary lookups one after the other. When either lookup misses, the block raises a line request and takes eight fill words in order. Each fill word goes into the bank that its parity selects. The block then replays the whole fetch. The refill path handles only one line at a time, and a split pair whose two lines are both absent is refilled line by line, lower line first. The requester holds `fetch_req` and `fetch_addr` steady while `out_stall` is high. Lines are written only by refill.

States: `ST_LOOKUP` is the normal single-cycle lookup. `ST_SPLIT_HI` is the second lookup of a pair that crosses a line. `ST_REFILL` collects fill words. Transitions:
- lookup-to-split: a crossing pair's lower line hits.
- lookup-to-refill: any miss in `ST_LOOKUP`.
- split-to-lookup: the upper line hits, and the pair is delivered.
- split-to-refill: the upper line misses.
- refill-to-lookup: the last fill word is written, and the lookup is replayed.

Top module: `stripe_fetch`

## Requirements
- R1: When `out_valid` is high, `out_word0` holds the instruction at `fetch_addr` and `out_word1` holds the instruction at `fetch_addr+1` (modulo the address width).
- R2: A pair whose start offset within its line is 0 to 6, even or odd, is delivered with `out_valid` high and `out_stall` low in the same cycle the request appears, provided its line is present.
- R3: A pair starting at line offset 7, with both lines present, stalls exactly one cycle and is delivered in the second cycle. It is never valid in the first cycle of its request.
- R4: On a miss, `miss_req` rises in the next cycle with `miss_line` = fetch word address shifted right by 3. `miss_line` stays stable until exactly 8 words have been accepted through `fill_valid`/`fill_word`. Word i of the burst is stored as word i of that line. No pair is valid while `miss_req` is high.
- R5: A pair within one absent line is delivered after exactly 9 stall cycles: one detect cycle and 8 fill cycles.
- R6: A crossing pair with both lines absent requests the lower line first, then the upper, and is delivered after 20 stall cycles. With only the upper line absent, it is delivered after 11 stall cycles.
- R7: Two lines whose word addresses differ by a multiple of 128 words (same index, different tag) evict each other.
- R8: After reset every line is invalid, and `miss_req` and `out_valid` are low.
- R9: `out_stall` is high exactly when `fetch_req` is high and `out_valid` is low. With no request, both are low.
- R10: A crossing pair at the last cache index continues into index 0 of the next tag, and both halves are returned correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_req | input | 1 | Fetch request, held while stalled |
| fetch_addr | input | 16 | Word address of the first instruction |
| out_word0 | output | 32 | Instruction at the lower address |
| out_word1 | output | 32 | Next sequential instruction |
| out_valid | output | 1 | Both output words are valid this cycle |
| out_stall | output | 1 | Request pending and not yet served |
| miss_req | output | 1 | Line refill request |
| miss_line | output | 13 | Line address to refill |
| fill_valid | input | 1 | Fill word present this cycle |
| fill_word | input | 32 | Fill word, sent in word order within the line |

## Verification
On every cycle, the assertions check several rules. Nothing is delivered without a request or during a refill. The refill line address is held steady, and each refill burst is exactly eight words long. A pair crossing a line is never delivered in the first cycle of its request. The bench scenarios are needed for the rest: the data in each lane, the exact stall counts for hits, cold misses, split hits and split misses, the order in which a split miss requests its two lines, and eviction and index wrap. Those scenarios compare against a memory model kept in the bench.

// File: rtl/stripe_fetch_pkg.sv
package stripe_fetch_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP   = 2'd0,
        ST_SPLIT_HI = 2'd1,
        ST_REFILL   = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/sf_tag_store.sv
module sf_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] line_ok;
    logic [TAG_W-1:0] tag_mem [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_ok <= '0;
        end else if (wr_en) begin
            line_ok[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_hit = line_ok[rd_idx] && (tag_mem[rd_idx] == rd_tag);
endmodule

// File: rtl/sf_word_bank.sv
module sf_word_bank #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/stripe_fetch.sv
module stripe_fetch
    import stripe_fetch_pkg::*;
#(
    parameter int WADDR_W    = 16,
    parameter int DW         = 32,
    parameter int LINE_WORDS = 8,
    parameter int LINES      = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   fetch_req,
    input  logic [WADDR_W-1:0]                     fetch_addr,
    output logic [DW-1:0]                          out_word0,
    output logic [DW-1:0]                          out_word1,
    output logic                                   out_valid,
    output logic                                   out_stall,
    output logic                                   miss_req,
    output logic [WADDR_W-$clog2(LINE_WORDS)-1:0]  miss_line,
    input  logic                                   fill_valid,
    input  logic [DW-1:0]                          fill_word
);
    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = WADDR_W - IDX_W - OFF_W;
    localparam int LADDR_W = WADDR_W - OFF_W;
    localparam int CW      = IDX_W + OFF_W;
    localparam int BANK_AW = CW - 1;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

    fetch_state_t state_q, state_d;

    logic [WADDR_W-1:0] addr_hi;
    logic [LADDR_W-1:0] line_lo, line_hi, look_line;
    logic               crosses, tag_hit;
    logic [CW-1:0]      cw_lo, cw_hi;
    logic [BANK_AW-1:0] bank_rd [2];
    logic [DW-1:0]      bank_q  [2];
    logic [DW-1:0]      lo_q, word_lo, word_hi;
    logic [LADDR_W-1:0] miss_line_q;
    logic [OFF_W-1:0]   fill_cnt_q;
    logic               capture_lo, start_miss, fill_last;

    assign addr_hi = fetch_addr + WADDR_W'(1);
    assign line_lo = fetch_addr[WADDR_W-1:OFF_W];
    assign line_hi = addr_hi[WADDR_W-1:OFF_W];
    assign crosses = (fetch_addr[OFF_W-1:0] == LAST_OFF);
    assign cw_lo   = fetch_addr[CW-1:0];
    assign cw_hi   = addr_hi[CW-1:0];

    // Even bank gets the even word of the pair, odd bank the odd word
    assign bank_rd[0] = fetch_addr[0] ? cw_hi[CW-1:1] : cw_lo[CW-1:1];
    assign bank_rd[1] = cw_lo[CW-1:1];
    assign word_lo    = bank_q[fetch_addr[0]];
    assign word_hi    = bank_q[~fetch_addr[0]];

    // One tag lookup per cycle: upper line only in the split state
    assign look_line = (state_q == ST_SPLIT_HI) ? line_hi : line_lo;
    assign fill_last = fill_valid && (fill_cnt_q == LAST_OFF);

    sf_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (look_line[IDX_W-1:0]),
        .rd_tag (look_line[LADDR_W-1:IDX_W]),
        .rd_hit (tag_hit),
        .wr_en  (state_q == ST_REFILL && fill_last),
        .wr_idx (miss_line_q[IDX_W-1:0]),
        .wr_tag (miss_line_q[LADDR_W-1:IDX_W])
    );

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            sf_word_bank #(.AW(BANK_AW), .DW(DW)) u_bank (
                .clk     (clk),
                .rd_addr (bank_rd[b]),
                .rd_data (bank_q[b]),
                .wr_en   (state_q == ST_REFILL && fill_valid && (fill_cnt_q[0] == 1'(b))),
                .wr_addr ({miss_line_q[IDX_W-1:0], fill_cnt_q[OFF_W-1:1]}),
                .wr_data (fill_word)
            );
        end
    endgenerate

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_LOOKUP;
            lo_q        <= '0;
            miss_line_q <= '0;
            fill_cnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture_lo) begin
                lo_q <= word_lo;
            end
            if (start_miss) begin
                miss_line_q <= look_line;
                fill_cnt_q  <= '0;
            end else if (state_q == ST_REFILL && fill_valid) begin
                fill_cnt_q <= fill_cnt_q + OFF_W'(1);
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        out_valid  = 1'b0;
        out_word0  = word_lo;
        out_word1  = word_hi;
        capture_lo = 1'b0;
        start_miss = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                if (fetch_req) begin
                    if (!tag_hit) begin
                        start_miss = 1'b1;
                        state_d    = ST_REFILL;
                    end else if (crosses) begin
                        capture_lo = 1'b1;
                        state_d    = ST_SPLIT_HI;
                    end else begin
                        out_valid = 1'b1;
                    end
                end
            end
            ST_SPLIT_HI: begin
                if (tag_hit) begin
                    out_valid = 1'b1;
                    out_word0 = lo_q;
                    state_d   = ST_LOOKUP;
                end else begin
                    start_miss = 1'b1;
                    state_d    = ST_REFILL;
                end
            end
            ST_REFILL: begin
                if (fill_last) begin
                    state_d = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    assign out_stall = fetch_req && !out_valid;
    assign miss_req  = (state_q == ST_REFILL);
    assign miss_line = miss_line_q;
endmodule

// File: rtl/stripe_fetch_chk.sv
module stripe_fetch_chk #(
    parameter int WADDR_W    = 16,
    parameter int LINE_WORDS = 8
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  fetch_req,
    input logic [WADDR_W-1:0]                    fetch_addr,
    input logic                                  out_valid,
    input logic                                  out_stall,
    input logic                                  miss_req,
    input logic [WADDR_W-$clog2(LINE_WORDS)-1:0] miss_line,
    input logic                                  fill_valid
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int CNT_W = OFF_W + 2;

    logic [CNT_W-1:0] fills_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fills_seen <= '0;
        end else if (miss_req) begin
            fills_seen <= fills_seen + CNT_W'(fill_valid);
        end else begin
            fills_seen <= '0;
        end
    end

    assert_valid_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fetch_req);

    assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |-> !out_stall);

    assert_refill_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> !out_valid);

    assert_miss_line_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && $past(miss_req)) |-> $stable(miss_line));

    assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(miss_req) |-> (fills_seen == CNT_W'(LINE_WORDS)));

    assert_split_not_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fetch_addr[OFF_W-1:0] == OFF_W'(LINE_WORDS - 1))
            |-> ($past(fetch_req) && $past(fetch_addr) == fetch_addr));

    assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!miss_req && !out_valid));
endmodule

bind stripe_fetch stripe_fetch_chk #(.WADDR_W(WADDR_W), .LINE_WORDS(LINE_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .out_valid  (out_valid),
    .out_stall  (out_stall),
    .miss_req   (miss_req),
    .miss_line  (miss_line),
    .fill_valid (fill_valid)
);

// File: tb/stripe_fetch_tb.sv
module stripe_fetch_tb;
    localparam int WADDR_W = 16;
    localparam int LW_W    = 13;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               fetch_req = 1'b0;
    logic [WADDR_W-1:0] fetch_addr = '0;
    logic [31:0]        out_word0, out_word1, fill_word;
    logic               out_valid, out_stall, miss_req, fill_valid;
    logic [LW_W-1:0]    miss_line;

    int n_checks = 0;
    int n_fails  = 0;
    logic [2:0]      fcnt = '0;
    logic            miss_prev = 1'b0;
    logic [LW_W-1:0] miss_log [16];
    int              miss_n = 0;

    always #10 clk = ~clk;

    stripe_fetch u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .out_word0(out_word0), .out_word1(out_word1), .out_valid(out_valid),
        .out_stall(out_stall), .miss_req(miss_req), .miss_line(miss_line),
        .fill_valid(fill_valid), .fill_word(fill_word)
    );

    function automatic logic [31:0] mem_word(input logic [WADDR_W-1:0] a);
        return {8'hC3, a[7:0] ^ 8'h5A, a};
    endfunction

    // Backing memory: one fill word per cycle while a line is requested
    assign fill_valid = miss_req;
    assign fill_word  = mem_word({miss_line, fcnt});

    always @(posedge clk) begin
        fcnt      <= (miss_req) ? fcnt + 3'd1 : 3'd0;
        miss_prev <= miss_req;
        if (miss_req && !miss_prev && miss_n < 16) begin
            miss_log[miss_n] <= miss_line;
            miss_n <= miss_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one fetch, count stall cycles, check both lanes and latency
    task automatic do_fetch(input string req, input logic [WADDR_W-1:0] a, input int exp_stalls);
        int stalls = 0;
        @(posedge clk); #1;
        fetch_req  = 1'b1;
        fetch_addr = a;
        @(negedge clk);
        while (!out_valid && stalls < 100) begin
            check({req, " stall while pending"}, 32'(out_stall), 32'd1);
            stalls++;
            @(negedge clk);
        end
        check({req, " lane0"}, out_word0, mem_word(a));
        check({req, " lane1"}, out_word1, mem_word(a + 16'd1));
        check({req, " stall cycles"}, 32'(stalls), 32'(exp_stalls));
        check({req, " stall low when valid"}, 32'(out_stall), 32'd0);
        @(posedge clk); #1;
        fetch_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8 valid after reset", 32'(out_valid), 32'd0);
        check("R8 miss_req after reset", 32'(miss_req), 32'd0);
        check("R9 stall without request", 32'(out_stall), 32'd0);
    endtask

    task automatic t_cold_inline();
        int base = miss_n;
        do_fetch("R5 cold inline miss", 16'h0010, 9);
        check("R4 miss line address", 32'(miss_log[base]), 32'h2);
        check("R4 one request", 32'(miss_n - base), 32'd1);
    endtask

    task automatic t_inline_hits();
        do_fetch("R2 even start hit", 16'h0012, 0);
        do_fetch("R2 odd start hit R1", 16'h0015, 0);
        do_fetch("R2 offset 6 hit", 16'h0016, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R9 idle stall", 32'(out_stall), 32'd0);
        check("R9 idle valid", 32'(out_valid), 32'd0);
    endtask

    task automatic t_split_hit();
        do_fetch("R5 load line 3", 16'h0018, 9);
        do_fetch("R3 split hit", 16'h0017, 1);
    endtask

    task automatic t_split_both_miss();
        int base = miss_n;
        do_fetch("R6 split both miss", 16'h002F, 20);
        check("R6 first request lower", 32'(miss_log[base]), 32'h5);
        check("R6 second request upper", 32'(miss_log[base+1]), 32'h6);
    endtask

    task automatic t_split_upper_miss();
        int base;
        do_fetch("R5 load line 8", 16'h0040, 9);
        base = miss_n;
        do_fetch("R6 split upper miss", 16'h0047, 11);
        check("R6 upper line requested", 32'(miss_log[base]), 32'h9);
        check("R6 only one request", 32'(miss_n - base), 32'd1);
    endtask

    task automatic t_evict();
        do_fetch("R7 resident before", 16'h0012, 0);
        do_fetch("R7 conflicting line", 16'h0092, 9);
        do_fetch("R7 evicted refetch", 16'h0012, 9);
    endtask

    task automatic t_wrap();
        int base = miss_n;
        do_fetch("R10 wrap split", 16'h007F, 20);
        check("R10 lower line", 32'(miss_log[base]), 32'hF);
        check("R10 upper line", 32'(miss_log[base+1]), 32'h10);
        do_fetch("R10 upper resident", 16'h0080, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_cold_inline();
        t_inline_hits();
        t_idle();
        t_split_hit();
        t_split_both_miss();
        t_split_upper_miss();
        t_evict();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule